// File: doc/BRIEF.md
# Clock Stop Gating Unit

This block sits between the clock sources of a system clock generator and its output drivers. It takes three source clocks (a CPU clock, a PCI clock and a memory clock) and fans each one out to one free-running copy and a group of gated copies. Two active-low stop requests can halt the gated copies. The CPU stop request controls both the CPU group and the memory group. The PCI stop request controls the PCI group. Stopping and restarting never shorten a pulse: a gated output either delivers a whole high phase or stays low for the whole cycle.

Each stop request is brought into the clock domain it controls through a flop chain. The CPU and memory domains use two stages, so stopping and restarting take a fixed two to three clocks. The PCI domain samples its request once, on the rising edge of the PCI clock, so the change applies from the next PCI cycle. A per-output enable mask from a configuration register can also force any single output low, free-running copies included. Mask changes follow the same no-runt rule.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every output is low.
- R2: When `cpu_stop_n` falls during the low phase before CPU rising edge k, the gated CPU outputs deliver full pulses at edges k and k+1. From edge k+2 on they stay low.
- R3: When `cpu_stop_n` rises during the low phase before CPU rising edge k, the gated CPU outputs stay low at edges k and k+1. Their first pulse, a full one, comes at edge k+2.
- R4: `pci_stop_n` is sampled on each rising edge of `pci_clk`. If the edge that samples it low is edge k, the pulse at edge k is completed and the gated PCI outputs stay low from edge k+1.
- R5: If the edge that samples `pci_stop_n` high is PCI edge k, the gated PCI outputs stay low at edge k. They restart with a full pulse at edge k+1.
- R6: The gated memory outputs follow `cpu_stop_n` with the same timing as R2 and R3, counted in `mem_clk` edges.
- R7: The free-running outputs `cpu_free`, `pci_free` and `mem_free` ignore both stop inputs.
- R8: Mask bit 0 of each domain's enable vector enables that domain's free copy. Bit i+1 enables gated output i. A 0 holds the output low. A change takes effect from the next falling edge of the source clock.
- R9: Every output is low whenever its source clock is low. Every high pulse lasts exactly the source clock's high phase.
- R10: A stop request affects only the domains it controls: `pci_stop_n` does not touch the CPU and memory groups, and `cpu_stop_n` does not touch the PCI group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | 1 | PCI source clock |
| mem_clk | input | 1 | Memory source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU and memory groups |
| pci_stop_n | input | 1 | Active-low stop request for the PCI group |
| cpu_en | input | CPU_N+1 | CPU enable mask (bit 0 free copy, bit i+1 gated output i) |
| pci_en | input | PCI_N+1 | PCI enable mask, same layout |
| mem_en | input | MEM_N+1 | Memory enable mask, same layout |
| cpu_free | output | 1 | Free-running CPU copy |
| cpu_out | output | CPU_N | Gated CPU copies |
| pci_free | output | 1 | Free-running PCI copy |
| pci_out | output | PCI_N | Gated PCI copies |
| mem_free | output | 1 | Free-running memory copy |
| mem_out | output | MEM_N | Gated memory copies |

## Verification
The bench counts pulses edge by edge right after each stop or restart. A synchronizer that is one stage too long or too short therefore shows up as an extra or a missing pulse at the second or third edge. Within every high phase it samples each output three times, and once more in the low phase. An enable that switched while the clock was high would show up as a truncated pulse or a glitch. It then sweeps every mask pattern of every domain under each combination of the two stop inputs. That catches a mask bit wired to the wrong output, a free copy that obeys a stop request, and a stop request that leaks into a domain it does not control.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Number of flops that release the reset inside each clock domain.
  localparam int unsigned RST_SYNC_STAGES = 2;

  // State of the enable flop that sits in front of each output AND gate.
  typedef enum logic {
    GATE_HOLD = 1'b0,
    GATE_PASS = 1'b1
  } gate_e;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d    = chain_q << 1;
    chain_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cs_stop_sync.sv
module cs_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  output logic run
);
  logic [STAGES-1:0] samp_q, samp_d;

  // Shift the request in on rising edges. Reset means "stopped".
  always_comb begin
    samp_d    = samp_q << 1;
    samp_d[0] = stop_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= samp_d;
  end

  assign run = samp_q[STAGES-1];
endmodule

// File: rtl/cs_gate_cell.sv
module cs_gate_cell
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  output logic gclk
);
  gate_e en_q, en_d;

  always_comb begin
    en_d = (run && en) ? GATE_PASS : GATE_HOLD;
  end

  // The enable is updated on the falling edge only. It is therefore stable
  // through every high phase, and the AND below can neither shorten nor split a pulse.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= GATE_HOLD;
    else        en_q <= en_d;
  end

  assign gclk = clk & (en_q == GATE_PASS);
endmodule

// File: rtl/cs_domain.sv
module cs_domain
  import clkstop_pkg::*;
#(
  parameter int unsigned N_GATED     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               stop_n,
  input  logic [N_GATED:0]   en,
  output logic               free_clk,
  output logic [N_GATED-1:0] gated_clk
);
  logic srst_n;
  logic run;

  cs_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  cs_stop_sync #(.STAGES(SYNC_STAGES)) u_stop (
    .clk    (clk),
    .rst_n  (srst_n),
    .stop_n (stop_n),
    .run    (run)
  );

  // The free copy obeys only its own mask bit.
  cs_gate_cell u_free (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (1'b1),
    .en    (en[0]),
    .gclk  (free_clk)
  );

  for (genvar g = 0; g < N_GATED; g++) begin : g_out
    cs_gate_cell u_cell (
      .clk   (clk),
      .rst_n (srst_n),
      .run   (run),
      .en    (en[g+1]),
      .gclk  (gated_clk[g])
    );
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned CPU_N    = 2,
  parameter int unsigned PCI_N    = 5,
  parameter int unsigned MEM_N    = 8,
  parameter int unsigned CPU_SYNC = 2,
  parameter int unsigned PCI_SYNC = 1
) (
  input  logic             cpu_clk,
  input  logic             pci_clk,
  input  logic             mem_clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic [CPU_N:0]   cpu_en,
  input  logic [PCI_N:0]   pci_en,
  input  logic [MEM_N:0]   mem_en,
  output logic             cpu_free,
  output logic [CPU_N-1:0] cpu_out,
  output logic             pci_free,
  output logic [PCI_N-1:0] pci_out,
  output logic             mem_free,
  output logic [MEM_N-1:0] mem_out
);
  cs_domain #(.N_GATED(CPU_N), .SYNC_STAGES(CPU_SYNC)) u_cpu (
    .clk       (cpu_clk),
    .arst_n    (rst_n),
    .stop_n    (cpu_stop_n),
    .en        (cpu_en),
    .free_clk  (cpu_free),
    .gated_clk (cpu_out)
  );

  cs_domain #(.N_GATED(PCI_N), .SYNC_STAGES(PCI_SYNC)) u_pci (
    .clk       (pci_clk),
    .arst_n    (rst_n),
    .stop_n    (pci_stop_n),
    .en        (pci_en),
    .free_clk  (pci_free),
    .gated_clk (pci_out)
  );

  // The memory group is halted by the CPU request, resampled in its own clock.
  cs_domain #(.N_GATED(MEM_N), .SYNC_STAGES(CPU_SYNC)) u_mem (
    .clk       (mem_clk),
    .arst_n    (rst_n),
    .stop_n    (cpu_stop_n),
    .en        (mem_en),
    .free_clk  (mem_free),
    .gated_clk (mem_out)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned CPU_N = 2,
  parameter int unsigned PCI_N = 5,
  parameter int unsigned MEM_N = 8
) (
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             mem_clk,
  input logic             rst_n,
  input logic             cpu_stop_n,
  input logic             pci_stop_n,
  input logic [CPU_N:0]   cpu_en,
  input logic [PCI_N:0]   pci_en,
  input logic [MEM_N:0]   mem_en,
  input logic             cpu_free,
  input logic [CPU_N-1:0] cpu_out,
  input logic             pci_free,
  input logic [PCI_N-1:0] pci_out,
  input logic             mem_free,
  input logic [MEM_N-1:0] mem_out
);
  // Cycles since reset, per domain. Checks that look back start only once
  // the reset release and the synchronizers have settled.
  logic [2:0] cpu_age, pci_age, mem_age;
  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) cpu_age <= '0; else if (cpu_age != 3'd7) cpu_age <= cpu_age + 3'd1;
  always_ff @(posedge pci_clk or negedge rst_n)
    if (!rst_n) pci_age <= '0; else if (pci_age != 3'd7) pci_age <= pci_age + 3'd1;
  always_ff @(posedge mem_clk or negedge rst_n)
    if (!rst_n) mem_age <= '0; else if (mem_age != 3'd7) mem_age <= mem_age + 3'd1;

  logic cpu_ok, pci_ok, mem_ok;
  assign cpu_ok = (cpu_age == 3'd7);
  assign pci_ok = (pci_age == 3'd7);
  assign mem_ok = (mem_age == 3'd7);

  // R2: a stop held for four CPU falling edges has silenced the gated CPU group.
  a_r2_cpu_hold: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (cpu_ok && !cpu_stop_n && $past(!cpu_stop_n) && $past(!cpu_stop_n, 2) && $past(!cpu_stop_n, 3))
      |-> (cpu_out == '0));

  // R3: a run request held for four falling edges lets the masked CPU group through.
  a_r3_cpu_run: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (cpu_ok && cpu_stop_n && $past(cpu_stop_n) && $past(cpu_stop_n, 2) && $past(cpu_stop_n, 3))
      |-> (cpu_out == $past(cpu_en[CPU_N:1])));

  // R4: with one sampling stage, three falling edges of stop silence the PCI group.
  a_r4_pci_hold: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (pci_ok && !pci_stop_n && $past(!pci_stop_n) && $past(!pci_stop_n, 2))
      |-> (pci_out == '0));

  // R5: PCI restart within the same window.
  a_r5_pci_run: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (pci_ok && pci_stop_n && $past(pci_stop_n) && $past(pci_stop_n, 2))
      |-> (pci_out == $past(pci_en[PCI_N:1])));

  // R6: the memory group obeys the CPU stop in its own clock.
  a_r6_mem_hold: assert property (@(negedge mem_clk) disable iff (!rst_n)
    (mem_ok && !cpu_stop_n && $past(!cpu_stop_n) && $past(!cpu_stop_n, 2) && $past(!cpu_stop_n, 3))
      |-> (mem_out == '0));

  // R7: the free copies follow only their mask bit.
  a_r7_cpu_free: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    cpu_ok |-> (cpu_free == $past(cpu_en[0])));
  a_r7_pci_free: assert property (@(negedge pci_clk) disable iff (!rst_n)
    pci_ok |-> (pci_free == $past(pci_en[0])));
  a_r7_mem_free: assert property (@(negedge mem_clk) disable iff (!rst_n)
    mem_ok |-> (mem_free == $past(mem_en[0])));

  // R9: nothing is high in the low phase of its source clock.
  a_r9_cpu_low: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (cpu_out == '0) && !cpu_free);
  a_r9_pci_low: assert property (@(posedge pci_clk) disable iff (!rst_n)
    (pci_out == '0) && !pci_free);
  a_r9_mem_low: assert property (@(posedge mem_clk) disable iff (!rst_n)
    (mem_out == '0) && !mem_free);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.CPU_N(CPU_N), .PCI_N(PCI_N), .MEM_N(MEM_N)) u_chk (
  .cpu_clk(cpu_clk), .pci_clk(pci_clk), .mem_clk(mem_clk), .rst_n(rst_n),
  .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
  .cpu_en(cpu_en), .pci_en(pci_en), .mem_en(mem_en),
  .cpu_free(cpu_free), .cpu_out(cpu_out), .pci_free(pci_free), .pci_out(pci_out),
  .mem_free(mem_free), .mem_out(mem_out)
);

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/1ps
module clk_stop_gate_bench;
  localparam int CN = 2, PN = 5, MN = 8;
  localparam int CP = 20, PP = 60, MP = 16;     // periods in ns
  localparam int WIN = 240;                     // common multiple of all periods
  localparam int CW = WIN / CP, PW = WIN / PP, MW = WIN / MP;

  logic cpu_clk = 1'b1, pci_clk = 1'b1, mem_clk = 1'b1;
  logic rst_n, cpu_stop_n, pci_stop_n;
  logic [CN:0] cpu_en;
  logic [PN:0] pci_en;
  logic [MN:0] mem_en;
  logic cpu_free, pci_free, mem_free;
  logic [CN-1:0] cpu_out;
  logic [PN-1:0] pci_out;
  logic [MN-1:0] mem_out;

  always #(CP/2) cpu_clk = ~cpu_clk;
  always #(PP/2) pci_clk = ~pci_clk;
  always #(MP/2) mem_clk = ~mem_clk;

  clk_stop_gate #(.CPU_N(CN), .PCI_N(PN), .MEM_N(MN)) u_clk_stop_gate (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .mem_clk(mem_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_en(cpu_en), .pci_en(pci_en), .mem_en(mem_en),
    .cpu_free(cpu_free), .cpu_out(cpu_out), .pci_free(pci_free), .pci_out(pci_out),
    .mem_free(mem_free), .mem_out(mem_out)
  );

  // Index 0 of each vector is the free copy, index i+1 is gated output i.
  logic [CN:0] cpu_all;
  logic [PN:0] pci_all;
  logic [MN:0] mem_all;
  assign cpu_all = {cpu_out, cpu_free};
  assign pci_all = {pci_out, pci_free};
  assign mem_all = {mem_out, mem_free};

  int cpu_cnt [0:CN];
  int pci_cnt [0:PN];
  int mem_cnt [0:MN];
  int cpu_s [0:CN];
  int pci_s [0:PN];
  int mem_s [0:MN];
  int cpu_bad = 0, pci_bad = 0, mem_bad = 0;
  int checks = 0, fails = 0;

  initial begin
    for (int i = 0; i <= CN; i++) cpu_cnt[i] = 0;
    for (int i = 0; i <= PN; i++) pci_cnt[i] = 0;
    for (int i = 0; i <= MN; i++) mem_cnt[i] = 0;
  end

  // Each monitor samples three times in the high phase and once in the low
  // phase. A pulse is counted when it is high in mid-phase.
  always @(posedge cpu_clk) begin
    logic [CN:0] a, b, c;
    #1 a = cpu_all; #4 b = cpu_all; #4 c = cpu_all;
    if (a != b || b != c) cpu_bad++;
    for (int i = 0; i <= CN; i++) if (b[i]) cpu_cnt[i]++;
    #6 if (cpu_all != '0) cpu_bad++;
  end
  always @(posedge pci_clk) begin
    logic [PN:0] a, b, c;
    #1 a = pci_all; #14 b = pci_all; #14 c = pci_all;
    if (a != b || b != c) pci_bad++;
    for (int i = 0; i <= PN; i++) if (b[i]) pci_cnt[i]++;
    #16 if (pci_all != '0) pci_bad++;
  end
  always @(posedge mem_clk) begin
    logic [MN:0] a, b, c;
    #1 a = mem_all; #3 b = mem_all; #3 c = mem_all;
    if (a != b || b != c) mem_bad++;
    for (int i = 0; i <= MN; i++) if (b[i]) mem_cnt[i]++;
    #5 if (mem_all != '0) mem_bad++;
  end

  task automatic cmp(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic snap_all();
    for (int i = 0; i <= CN; i++) cpu_s[i] = cpu_cnt[i];
    for (int i = 0; i <= PN; i++) pci_s[i] = pci_cnt[i];
    for (int i = 0; i <= MN; i++) mem_s[i] = mem_cnt[i];
  endtask

  // Settle, then count pulses over one aligned window of WIN ns.
  task automatic measure();
    #200;
    #(WIN - ($time % WIN));
    snap_all();
    #WIN;
  endtask

  // R7 R8 R10: compare every output's pulse count with the mask and stop state.
  task automatic check_window(input string req);
    for (int i = 0; i <= CN; i++)
      cmp(req, $sformatf("cpu[%0d] en=%b stop_n=%b", i, cpu_en, cpu_stop_n),
          cpu_cnt[i] - cpu_s[i], (cpu_en[i] && (i == 0 || cpu_stop_n)) ? CW : 0);
    for (int i = 0; i <= PN; i++)
      cmp(req, $sformatf("pci[%0d] en=%b stop_n=%b", i, pci_en, pci_stop_n),
          pci_cnt[i] - pci_s[i], (pci_en[i] && (i == 0 || pci_stop_n)) ? PW : 0);
    for (int i = 0; i <= MN; i++)
      cmp(req, $sformatf("mem[%0d] en=%b stop_n=%b", i, mem_en, cpu_stop_n),
          mem_cnt[i] - mem_s[i], (mem_en[i] && (i == 0 || cpu_stop_n)) ? MW : 0);
  endtask

  bit done = 1'b0;
  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    cpu_en = '1; pci_en = '1; mem_en = '1;
    // R1: the sample points fall inside high phases of the source clocks.
    #5  cmp("R1", "cpu during reset", int'(cpu_all), 0);
        cmp("R1", "mem during reset", int'(mem_all), 0);
    #10 cmp("R1", "pci during reset", int'(pci_all), 0);
    #88 rst_n = 1'b1;
    measure();
    check_window("R8");

    // R2: stop in the low phase before edge k. Pulses at k and k+1, none later.
    @(posedge cpu_clk); #12 cpu_stop_n = 1'b0; snap_all();
    repeat (2) @(posedge cpu_clk); #12;
    for (int i = 1; i <= CN; i++) cmp("R2", $sformatf("cpu gated %0d after 2 edges", i), cpu_cnt[i] - cpu_s[i], 2);
    repeat (3) @(posedge cpu_clk); #12;
    for (int i = 1; i <= CN; i++) cmp("R2", $sformatf("cpu gated %0d after 5 edges", i), cpu_cnt[i] - cpu_s[i], 2);
    cmp("R7", "cpu free during stop", cpu_cnt[0] - cpu_s[0], 5);
    // R3: restart. Quiet at k and k+1, first pulse at k+2.
    @(posedge cpu_clk); #12 cpu_stop_n = 1'b1; snap_all();
    repeat (2) @(posedge cpu_clk); #12;
    for (int i = 1; i <= CN; i++) cmp("R3", $sformatf("cpu gated %0d after 2 edges", i), cpu_cnt[i] - cpu_s[i], 0);
    @(posedge cpu_clk); #12;
    for (int i = 1; i <= CN; i++) cmp("R3", $sformatf("cpu gated %0d after 3 edges", i), cpu_cnt[i] - cpu_s[i], 1);

    // R4: stop seen at PCI edge k. The pulse at k completes, then low.
    @(posedge pci_clk); #40 pci_stop_n = 1'b0; snap_all();
    @(posedge pci_clk); #40;
    for (int i = 1; i <= PN; i++) cmp("R4", $sformatf("pci gated %0d after 1 edge", i), pci_cnt[i] - pci_s[i], 1);
    repeat (3) @(posedge pci_clk); #40;
    for (int i = 1; i <= PN; i++) cmp("R4", $sformatf("pci gated %0d after 4 edges", i), pci_cnt[i] - pci_s[i], 1);
    cmp("R7", "pci free during stop", pci_cnt[0] - pci_s[0], 4);
    // R5: restart seen at edge k, first pulse at k+1.
    @(posedge pci_clk); #40 pci_stop_n = 1'b1; snap_all();
    @(posedge pci_clk); #40;
    for (int i = 1; i <= PN; i++) cmp("R5", $sformatf("pci gated %0d after 1 edge", i), pci_cnt[i] - pci_s[i], 0);
    @(posedge pci_clk); #40;
    for (int i = 1; i <= PN; i++) cmp("R5", $sformatf("pci gated %0d after 2 edges", i), pci_cnt[i] - pci_s[i], 1);

    // R6: the memory group obeys the CPU stop, counted in memory clock edges.
    @(posedge mem_clk); #10 cpu_stop_n = 1'b0; snap_all();
    repeat (2) @(posedge mem_clk); #10;
    for (int i = 1; i <= MN; i++) cmp("R6", $sformatf("mem gated %0d stop 2 edges", i), mem_cnt[i] - mem_s[i], 2);
    repeat (3) @(posedge mem_clk); #10;
    for (int i = 1; i <= MN; i++) cmp("R6", $sformatf("mem gated %0d stop 5 edges", i), mem_cnt[i] - mem_s[i], 2);
    @(posedge mem_clk); #10 cpu_stop_n = 1'b1; snap_all();
    repeat (2) @(posedge mem_clk); #10;
    for (int i = 1; i <= MN; i++) cmp("R6", $sformatf("mem gated %0d run 2 edges", i), mem_cnt[i] - mem_s[i], 0);
    @(posedge mem_clk); #10;
    for (int i = 1; i <= MN; i++) cmp("R6", $sformatf("mem gated %0d run 3 edges", i), mem_cnt[i] - mem_s[i], 1);

    // R7 R8 R10: sweep every mask of each domain under every stop combination.
    // The mask is changed at an offset unrelated to any clock edge.
    for (int p = 0; p < (1 << (CN + 1)); p++) begin
      #7 cpu_en = p[CN:0]; cpu_stop_n = p[0] ^ p[1]; pci_stop_n = ~p[2];
      measure(); check_window("R8 R10");
    end
    cpu_en = '1;
    for (int p = 0; p < (1 << (PN + 1)); p++) begin
      #11 pci_en = p[PN:0]; pci_stop_n = p[1] ^ p[3]; cpu_stop_n = ~p[0];
      measure(); check_window("R7 R8 R10");
    end
    pci_en = '1;
    for (int p = 0; p < (1 << (MN + 1)); p++) begin
      #3 mem_en = p[MN:0]; cpu_stop_n = p[2] ^ p[5]; pci_stop_n = p[4];
      measure(); check_window("R7 R8");
    end

    // R9: no truncated pulse and no high level in any low phase, over the whole run.
    cmp("R9", "cpu runt or low-phase glitch count", cpu_bad, 0);
    cmp("R9", "pci runt or low-phase glitch count", pci_bad, 0);
    cmp("R9", "mem runt or low-phase glitch count", mem_bad, 0);
    finish_run();
  end
endmodule